// File: doc/BRIEF.md
# Four-Channel Programmable Clock Divider

This block turns one fast source clock into four slower clocks. Software picks each channel's division ratio by writing a 6-bit field in a shared 32-bit control word. It then commits that field by pulsing a load bit that sits just above the field. The divisor counts in units of source clock cycles. Channel 0 reads its field as a code that selects a divisor from a fixed, non-monotonic table. Channels 1 to 3 use the field value itself as the divisor.

A second 32-bit register carries a global run control. While its run bit is low, every divider is stopped and held at the start of its period. Software raises the run bit before it reprograms any divisor.

A committed divisor does not change the output at once. It is kept as pending and replaces the active divisor only at the end of the current output period, so an output never shows a shortened pulse. Both registers can be read back through the same simple write/read port.

Top module: `clkdiv_quad`

## Requirements
- R1: The divisor register is at byte offset 0x0 and the control register is at byte offset 0x4. Each reads back the last value written to it. Any other offset reads zero, and a write to any other offset changes nothing.
- R2: Channel k (k = 0..3) takes its 6-bit field from bits [7k+6:7k+1] of the divisor register. Its load bit is bit 7k+7.
- R3: A channel commits its field only on a rising edge of its load bit. Changing the field while the load bit stays steady leaves the output unchanged.
- R4: A committed divisor takes effect only when the current output period ends, or at once while the dividers are stopped. If a second commit arrives before that point, the later value wins.
- R5: Channel 0 maps codes 1..10 to divisors 2, 1, 3, 4, 6, 5, 7, 8, 10 and 9, in that order.
- R6: Channels 1 to 3 divide by the raw field value, which may be any value from 1 to 63.
- R7: An illegal setting is ignored and the active divisor is kept. Illegal settings are field 0 on any channel and codes 11..63 on channel 0.
- R8: For a divisor N of 2 or more, the output has a period of N source cycles. It is high for the first floor(N/2) cycles and low for the rest.
- R9: For a divisor of 1, the output follows the source clock.
- R10: Bit 10 of the control register is the run bit, active high. While it is low, all four outputs are low. Once it is raised, each channel starts a fresh period at the start of its high phase.
- R11: After reset, every channel divides by 1 and the divisor register reads 0x00408104, which is code 2 on channel 0 and 1 on channels 1 to 3. The control register reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock that all channels divide |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 3 | Byte offset of the register to access |
| wrData | input | 32 | Data to write |
| rdData | output | 32 | Combinational read data for addr |
| clkOut | output | 4 | Divided clocks, one per channel |

## Verification
The test starts with all channels dividing by 1 while the run bit is off, then turns the run bit on. Next it steps channel 0 through every legal code, so that any mistake in the shuffled table changes a period or a duty cycle. Channels 1 to 3 are run at even, odd and extreme divisors, which separates a period error from a duty-cycle error. Further sequences try illegal fields and field edits with no load pulse, and each should change nothing. A long period is reloaded in the middle of the period, to show that the switch waits for the end of the period. A commit is made while the dividers are stopped, to check that the new value applies at once and that the restart begins with the high phase.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int NCH        = 4;   // number of output channels
  localparam int DW         = 6;   // divisor field width
  localparam int REG_W      = 32;  // register width
  localparam int FIELD_BASE = 1;   // lsb of channel 0 field
  localparam int STRIDE     = DW + 1;
  localparam logic [DW-1:0] CODE_FOR_ONE = DW'(2);

  typedef struct packed {
    logic                    run;
    logic [NCH-1:0]          load;
    logic [NCH-1:0][DW-1:0]  div;
  } ctl2dp_t;

  function automatic int fieldLsb(input int ch);
    return FIELD_BASE + ch * STRIDE;
  endfunction

  function automatic int loadPos(input int ch);
    return fieldLsb(ch) + DW;
  endfunction

  // Channel 0 code -> divisor; zero means the code is not usable
  function automatic logic [DW-1:0] decodeCode(input logic [DW-1:0] code);
    logic [DW-1:0] d;
    case (code)
      DW'(1):  d = DW'(2);
      DW'(2):  d = DW'(1);
      DW'(3):  d = DW'(3);
      DW'(4):  d = DW'(4);
      DW'(5):  d = DW'(6);
      DW'(6):  d = DW'(5);
      DW'(7):  d = DW'(7);
      DW'(8):  d = DW'(8);
      DW'(9):  d = DW'(10);
      DW'(10): d = DW'(9);
      default: d = '0;
    endcase
    return d;
  endfunction

  function automatic logic [REG_W-1:0] resetDivReg();
    logic [REG_W-1:0] v;
    v = '0;
    for (int i = 0; i < NCH; i++)
      v[fieldLsb(i) +: DW] = (i == 0) ? CODE_FOR_ONE : DW'(1);
    return v;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int RUN_BIT = 10,
  parameter int DIV_OFS = 0,
  parameter int CTL_OFS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output ctl2dp_t           stb
);
  localparam logic [REG_W-1:0] DIV_RST = resetDivReg();

  logic [REG_W-1:0] divReg;
  logic [REG_W-1:0] ctlReg;
  logic [NCH-1:0]   loadNow;
  logic [NCH-1:0]   loadPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg <= DIV_RST;
      ctlReg <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_W'(DIV_OFS)) divReg <= wrData;
      else if (addr == ADDR_W'(CTL_OFS)) ctlReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loadPrev <= '0;
    else       loadPrev <= loadNow;
  end

  always_comb begin
    if (addr == ADDR_W'(DIV_OFS))      rdData = divReg;
    else if (addr == ADDR_W'(CTL_OFS)) rdData = ctlReg;
    else                               rdData = '0;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] field;
    logic [DW-1:0] divisor;
    assign field       = divReg[fieldLsb(g) +: DW];
    assign loadNow[g]  = divReg[loadPos(g)];
    if (g == 0) begin : g_coded
      assign divisor = decodeCode(field);
    end else begin : g_raw
      assign divisor = field;
    end
    assign stb.div[g]  = divisor;
    assign stb.load[g] = loadNow[g] && !loadPrev[g] && (divisor != '0);
  end

  assign stb.run = ctlReg[RUN_BIT];
endmodule

// File: rtl/clkdiv_engine.sv
module clkdiv_engine
  import clkdiv_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  ctl2dp_t                 stb,
  output logic [NCH-1:0][DW-1:0]  actDiv,
  output logic [NCH-1:0][DW-1:0]  cnt,
  output logic [NCH-1:0]          pendValid,
  output logic [NCH-1:0]          clkOut
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] pendDiv;
    logic          atWrap;
    logic          periodEnd;

    assign periodEnd = (cnt[g] == actDiv[g] - DW'(1));
    assign atWrap    = !stb.run || periodEnd;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        actDiv[g]    <= DW'(1);
        cnt[g]       <= '0;
        pendDiv      <= '0;
        pendValid[g] <= 1'b0;
      end else begin
        if (atWrap) cnt[g] <= '0;
        else        cnt[g] <= cnt[g] + DW'(1);

        if (atWrap) begin
          if (stb.load[g])       actDiv[g] <= stb.div[g];
          else if (pendValid[g]) actDiv[g] <= pendDiv;
          pendValid[g] <= 1'b0;
        end else if (stb.load[g]) begin
          pendDiv      <= stb.div[g];
          pendValid[g] <= 1'b1;
        end
      end
    end

    always_comb begin
      if (!stb.run)                  clkOut[g] = 1'b0;
      else if (actDiv[g] == DW'(1))  clkOut[g] = clk;
      else                           clkOut[g] = (cnt[g] < (actDiv[g] >> 1));
    end
  end
endmodule

// File: rtl/clkdiv_quad.sv
module clkdiv_quad
  import clkdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic [3:0]  clkOut
);
  ctl2dp_t                 stb;
  logic [NCH-1:0][DW-1:0]  actDiv;
  logic [NCH-1:0][DW-1:0]  cnt;
  logic [NCH-1:0]          pendValid;

  clkdiv_regs #(.ADDR_W(3), .RUN_BIT(10)) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .stb    (stb)
  );

  clkdiv_engine u_engine (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .actDiv    (actDiv),
    .cnt       (cnt),
    .pendValid (pendValid),
    .clkOut    (clkOut)
  );
endmodule

// File: rtl/clkdiv_quad_chk.sv
module clkdiv_quad_chk
  import clkdiv_pkg::*;
(
  input logic                    clk,
  input logic                    rstN,
  input logic                    run,
  input logic [NCH-1:0]          loadStb,
  input logic [NCH-1:0]          pendValid,
  input logic [NCH-1:0][DW-1:0]  actDiv,
  input logic [NCH-1:0][DW-1:0]  cnt,
  input logic [NCH-1:0]          clkOut
);
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> (clkOut == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    a_r4_switch_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(actDiv[g]) |->
        (!$past(run) || ($past(cnt[g]) == $past(actDiv[g]) - DW'(1))));

    a_r3_switch_needs_commit: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(actDiv[g]) |-> $past(loadStb[g] || pendValid[g]));

    a_r8_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
      cnt[g] < actDiv[g]);

    a_r7_nonzero_div: assert property (@(posedge clk) disable iff (!rstN)
      actDiv[g] != '0);

    if (g == 0) begin : g_tab
      a_r5_ch0_range: assert property (@(posedge clk) disable iff (!rstN)
        actDiv[g] <= DW'(10));
    end
  end
endmodule

bind clkdiv_quad clkdiv_quad_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .run       (stb.run),
  .loadStb   (stb.load),
  .pendValid (pendValid),
  .actDiv    (actDiv),
  .cnt       (cnt),
  .clkOut    (clkOut)
);

// File: tb/test_clkdiv_quad.sv
`timescale 1ns/1ps
module test_clkdiv_quad;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  clkOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  string curTag = "R11";

  // behavioural reference state
  int unsigned mReg0, mReg1;
  int mPrev[4], mPend[4], mPv[4], mAct[4], mCnt[4];

  always #4 clk = ~clk;

  clkdiv_quad i_clkdiv_quad (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .clkOut(clkOut)
  );

  function automatic int ch0Map(int code);
    int t[11] = '{0, 2, 1, 3, 4, 6, 5, 7, 8, 10, 9};
    if (code >= 1 && code <= 10) return t[code];
    return 0;
  endfunction

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mReg0 = 32'h0040_8104;
      mReg1 = 0;
      for (int c = 0; c < 4; c++) begin
        mPrev[c] = 0; mPend[c] = 0; mPv[c] = 0; mAct[c] = 1; mCnt[c] = 0;
      end
    end else begin
      int run;
      run = (mReg1 >> 10) & 1;
      for (int c = 0; c < 4; c++) begin
        int base, fld, ld, d, strobe, wrap, nc;
        base = 1 + 7 * c;
        fld = (mReg0 >> base) & 63;
        ld = (mReg0 >> (base + 6)) & 1;
        d = (c == 0) ? ch0Map(fld) : fld;
        strobe = (ld == 1 && mPrev[c] == 0 && d != 0) ? 1 : 0;
        wrap = (run == 0 || mCnt[c] == mAct[c] - 1) ? 1 : 0;
        nc = wrap ? 0 : mCnt[c] + 1;
        if (wrap) begin
          if (strobe) mAct[c] = d;
          else if (mPv[c]) mAct[c] = mPend[c];
          mPv[c] = 0;
        end else if (strobe) begin
          mPend[c] = d; mPv[c] = 1;
        end
        mCnt[c] = nc;
        mPrev[c] = ld;
      end
      if (wrEn) begin
        if (addr == 3'd0) mReg0 = wrData;
        else if (addr == 3'd4) mReg1 = wrData;
      end
    end
    #1;
    if (!finished) begin
      int run2;
      longint expRd;
      run2 = (mReg1 >> 10) & 1;
      for (int c = 0; c < 4; c++) begin
        int e;
        if (run2 == 0) e = 0;
        else if (mAct[c] == 1) e = 1;
        else e = (mCnt[c] < mAct[c] / 2) ? 1 : 0;
        chk(curTag, $sformatf("ch%0d clkOut", c), clkOut[c], e);
      end
      expRd = (addr == 3'd0) ? mReg0 : (addr == 3'd4) ? mReg1 : 0;
      chk("R1", "rdData", rdData, expRd);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // write field with load low, pulse load, drop load
  task automatic loadCh(int ch, int code);
    int base;
    logic [31:0] v;
    base = 1 + 7 * ch;
    v = (mReg0 & ~(32'h7F << base)) | (32'(code) << base);
    wr(3'd0, v);
    wr(3'd0, v | (32'h1 << (base + 6)));
    idle(3);
    wr(3'd0, v);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    curTag = "R11";
    idle(3);
    addr = 3'd0; #1;
    chk("R11", "reset divisor reg", rdData, 32'h0040_8104);
    addr = 3'd4; #1;
    chk("R11", "reset control reg", rdData, 0);
    chk("R10", "outputs while stopped", clkOut, 0);
    @(negedge clk); rstN = 1'b1;
    idle(4);

    curTag = "R9";
    wr(3'd4, 32'h1 << 10);
    idle(20);

    curTag = "R6";
    loadCh(1, 5);
    loadCh(2, 63);
    loadCh(3, 2);
    idle(150);
    curTag = "R8";
    loadCh(1, 6);
    loadCh(3, 3);
    idle(80);

    curTag = "R5";
    for (int code = 1; code <= 10; code++) begin
      loadCh(0, code);
      idle(30);
    end

    curTag = "R7";
    loadCh(1, 0);
    loadCh(0, 11);
    loadCh(0, 0);
    loadCh(0, 63);
    idle(40);

    curTag = "R3";
    begin
      logic [31:0] v;
      v = (mReg0 & ~(32'h7F << 8)) | (32'd9 << 8);
      wr(3'd0, v);
      idle(40);
    end

    curTag = "R4";
    loadCh(2, 63);
    idle(70);
    loadCh(2, 4);
    idle(30);
    loadCh(3, 20);
    loadCh(3, 7);
    idle(60);

    curTag = "R10";
    wr(3'd4, 32'h0);
    idle(10);
    loadCh(1, 4);
    idle(5);
    wr(3'd4, 32'h1 << 10);
    idle(30);

    curTag = "R2";
    loadCh(0, 4);
    loadCh(1, 2);
    loadCh(2, 5);
    loadCh(3, 9);
    idle(60);

    curTag = "R1";
    wr(3'd2, 32'hFFFF_FFFF);
    addr = 3'd2; idle(3);
    wr(3'd4, 32'h0000_0400);
    addr = 3'd4; idle(3);
    addr = 3'd0; idle(3);
    addr = 3'd6; idle(3);
    finishRun();
  end
endmodule